// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical raster timing for a video output path. Software programs a compare value for every timing edge: the line and frame length, the border window, the display window and the sync start on each axis. A horizontal counter runs in pixel ticks and a vertical counter runs in half-lines. The block decodes hsync, vsync, display-enable, border-enable, an end-of-line pulse and an end-of-frame pulse from these counters.

A pixel-clock enable, divided by a programmable ratio, paces the counters. Interlace makes alternate fields start half a line later. Double scan makes the fetch line index, which a memory fetch unit would use, advance once per pair of displayed lines. Register writes land in a shadow copy. The whole shadow copy moves into the active set at the end of a frame, so a frame never mixes old and new timing.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is high, and on the first clock after it, display, border, eol and eof are low, field and fetch_line are 0, and each sync pin sits at its inactive level for the reset polarity (high when polarity is 0). Shadow and active registers take the reset values given by the parameters.
- R2: A tick occurs when pix_en is high and the count of pix_en cycles since the last tick has reached the divide limit. Mode bits [3:2] select the ratio: 00 gives divide by 4, 01 gives divide by 2, and 10 or 11 give divide by 1. Counters move only on ticks.
- R3: The horizontal counter steps 0..h_total and then wraps to 0. eol is high for exactly the clock after a tick taken at h_total. Every output is registered, so after a clock edge it reflects the counter state from before that edge.
- R4: At each line wrap the vertical counter advances by 2 half-lines. The frame ends at the line wrap where vc+2 exceeds v_total. eof pulses together with eol at that point.
- R5: hsync is active while hc >= h_ss, and vsync is active while vc >= v_ss. Control register (address 12) bit 0 sets hsync polarity and bit 1 sets vsync polarity, where 1 means active-high and 0 means active-low.
- R6: disp_en is high when hc is in [hdb, h_de) and vc is in [v_db, v_de). hdb is h_db[8:0], plus (h_total+1)/2 when h_db bit 9 is set, so display then starts in the second half-line.
- R7: border_en is high when hc is in [h_bb, h_be), vc is in [v_bb, v_be) and disp_en is low.
- R8: When mode bit 1 (interlace) is set, field toggles at every frame end and the odd field starts vc at 1. With interlace off, field returns to 0 and vc starts at 0.
- R9: fetch_line is 0 at frame start. It increments at the end of each line whose vc lies in [v_db, v_de). When mode bit 0 (double scan) is set, it increments only at every second such line.
- R10: Addresses are 0 h_total, 1 h_bb, 2 h_be, 3 h_db, 4 h_de, 5 h_ss, 6 v_total, 7 v_bb, 8 v_be, 9 v_db, 10 v_de, 11 v_ss, 12 control and 13 mode. Writes go to the shadow set, and writes to 14 and 15 are ignored. The active set loads from the shadow only at a frame end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 11 | Register write data |
| pix_en | input | 1 | Pixel clock enable |
| hsync | output | 1 | Horizontal sync, programmed polarity |
| vsync | output | 1 | Vertical sync, programmed polarity |
| disp_en | output | 1 | Active display region |
| border_en | output | 1 | Border region outside display |
| eol | output | 1 | End-of-line pulse |
| eof | output | 1 | End-of-frame pulse |
| field | output | 1 | Current interlace field |
| fetch_line | output | 11 | Line index for memory fetch |

## Verification
On every cycle the assertions check the following. eof never appears without eol. Display and border never overlap. The horizontal counter stays within its period and moves only on a tick. The active timing set changes only at a frame end. The field toggles or clears correctly at each frame end, and fetch_line only holds, steps by one or restarts. Only the bench scenarios can show the exact placement of sync, display and border edges, the half-line display start, and the divider ratios measured as eol spacing. They also show the double-scan fetch sequence and that a mid-frame write stays invisible until the frame boundary. The bench compares all of these against a reference model cycle by cycle.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int NREG = 14;

  typedef enum logic [3:0] {
    A_HTOT = 4'd0, A_HBB = 4'd1, A_HBE = 4'd2, A_HDB = 4'd3, A_HDE = 4'd4,
    A_HSS = 4'd5, A_VTOT = 4'd6, A_VBB = 4'd7, A_VBE = 4'd8, A_VDB = 4'd9,
    A_VDE = 4'd10, A_VSS = 4'd11, A_CTRL = 4'd12, A_MODE = 4'd13
  } reg_addr_e;

  function automatic logic [1:0] div_limit(input logic [1:0] code);
    case (code)
      2'b00:   div_limit = 2'd3;
      2'b01:   div_limit = 2'd1;
      default: div_limit = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs import rtg_pkg::*; #(
  parameter int HW = 9,
  parameter int VW = 11,
  parameter int DW = 11,
  parameter int AW = 4,
  parameter int RST_H [6] = '{63, 2, 60, 8, 56, 58},
  parameter int RST_V [6] = '{39, 2, 36, 4, 32, 34},
  parameter int RST_CTRL = 0,
  parameter int RST_MODE = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          load,
  output logic [HW-1:0] h_total,
  output logic [HW-1:0] h_bb,
  output logic [HW-1:0] h_be,
  output logic [HW:0]   h_db,
  output logic [HW-1:0] h_de,
  output logic [HW-1:0] h_ss,
  output logic [VW-1:0] v_total,
  output logic [VW-1:0] v_bb,
  output logic [VW-1:0] v_be,
  output logic [VW-1:0] v_db,
  output logic [VW-1:0] v_de,
  output logic [VW-1:0] v_ss,
  output logic          hpol,
  output logic          vpol,
  output logic          dscan,
  output logic          ilace,
  output logic [1:0]    div
);
  typedef struct packed {
    logic [HW-1:0] h_total, h_bb, h_be;
    logic [HW:0]   h_db;
    logic [HW-1:0] h_de, h_ss;
    logic [VW-1:0] v_total, v_bb, v_be, v_db, v_de, v_ss;
    logic          hpol, vpol, dscan, ilace;
    logic [1:0]    div;
  } cfg_t;

  function automatic cfg_t reset_cfg();
    cfg_t c;
    c.h_total = HW'(RST_H[0]);
    c.h_bb    = HW'(RST_H[1]);
    c.h_be    = HW'(RST_H[2]);
    c.h_db    = (HW+1)'(RST_H[3]);
    c.h_de    = HW'(RST_H[4]);
    c.h_ss    = HW'(RST_H[5]);
    c.v_total = VW'(RST_V[0]);
    c.v_bb    = VW'(RST_V[1]);
    c.v_be    = VW'(RST_V[2]);
    c.v_db    = VW'(RST_V[3]);
    c.v_de    = VW'(RST_V[4]);
    c.v_ss    = VW'(RST_V[5]);
    c.hpol    = RST_CTRL[0];
    c.vpol    = RST_CTRL[1];
    c.dscan   = RST_MODE[0];
    c.ilace   = RST_MODE[1];
    c.div     = RST_MODE[3:2];
    return c;
  endfunction

  localparam cfg_t RST_CFG = reset_cfg();

  cfg_t shadow, active;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= RST_CFG;
      active <= RST_CFG;
    end else begin
      if (load) active <= shadow;
      if (wr_en) begin
        case (reg_addr_e'(wr_addr))
          A_HTOT: shadow.h_total <= wr_data[HW-1:0];
          A_HBB:  shadow.h_bb    <= wr_data[HW-1:0];
          A_HBE:  shadow.h_be    <= wr_data[HW-1:0];
          A_HDB:  shadow.h_db    <= wr_data[HW:0];
          A_HDE:  shadow.h_de    <= wr_data[HW-1:0];
          A_HSS:  shadow.h_ss    <= wr_data[HW-1:0];
          A_VTOT: shadow.v_total <= wr_data[VW-1:0];
          A_VBB:  shadow.v_bb    <= wr_data[VW-1:0];
          A_VBE:  shadow.v_be    <= wr_data[VW-1:0];
          A_VDB:  shadow.v_db    <= wr_data[VW-1:0];
          A_VDE:  shadow.v_de    <= wr_data[VW-1:0];
          A_VSS:  shadow.v_ss    <= wr_data[VW-1:0];
          A_CTRL: {shadow.vpol, shadow.hpol} <= wr_data[1:0];
          A_MODE: {shadow.div, shadow.ilace, shadow.dscan} <= wr_data[3:0];
          default: ;
        endcase
      end
    end
  end

  assign h_total = active.h_total;
  assign h_bb    = active.h_bb;
  assign h_be    = active.h_be;
  assign h_db    = active.h_db;
  assign h_de    = active.h_de;
  assign h_ss    = active.h_ss;
  assign v_total = active.v_total;
  assign v_bb    = active.v_bb;
  assign v_be    = active.v_be;
  assign v_db    = active.v_db;
  assign v_de    = active.v_de;
  assign v_ss    = active.v_ss;
  assign hpol    = active.hpol;
  assign vpol    = active.vpol;
  assign dscan   = active.dscan;
  assign ilace   = active.ilace;
  assign div     = active.div;
endmodule

// File: rtl/rtg_tick.sv
module rtg_tick import rtg_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       pix_en,
  input  logic [1:0] div,
  output logic       tick
);
  logic [1:0] cnt;

  assign tick = pix_en && (cnt >= div_limit(div));

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (tick)   cnt <= '0;
    else if (pix_en) cnt <= cnt + 2'd1;
  end
endmodule

// File: rtl/rtg_counters.sv
module rtg_counters #(
  parameter int HW = 9,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [HW-1:0] h_total,
  input  logic [VW-1:0] v_total,
  input  logic [VW-1:0] v_db,
  input  logic [VW-1:0] v_de,
  input  logic          ilace,
  input  logic          dscan,
  output logic [HW-1:0] hc,
  output logic [VW-1:0] vc,
  output logic          field,
  output logic [VW-1:0] fetch_line,
  output logic          line_end,
  output logic          frame_end
);
  logic          ds_phase;
  logic          vdisp;
  logic [VW:0]   vc_next;

  assign vc_next   = {1'b0, vc} + (VW+1)'(2);
  assign line_end  = tick && (hc >= h_total);
  assign frame_end = line_end && (vc_next > {1'b0, v_total});
  assign vdisp     = (vc >= v_db) && (vc < v_de);

  always_ff @(posedge clk) begin
    if (rst) begin
      hc         <= '0;
      vc         <= '0;
      field      <= 1'b0;
      fetch_line <= '0;
      ds_phase   <= 1'b0;
    end else if (tick) begin
      if (line_end) begin
        hc <= '0;
        if (frame_end) begin
          field      <= ilace ? ~field : 1'b0;
          vc         <= (ilace && !field) ? VW'(1) : '0;
          fetch_line <= '0;
          ds_phase   <= 1'b0;
        end else begin
          vc <= vc_next[VW-1:0];
          if (vdisp) begin
            if (dscan) begin
              ds_phase <= ~ds_phase;
              if (ds_phase) fetch_line <= fetch_line + VW'(1);
            end else begin
              fetch_line <= fetch_line + VW'(1);
            end
          end
        end
      end else begin
        hc <= hc + HW'(1);
      end
    end
  end
endmodule

// File: rtl/rtg_decode.sv
module rtg_decode #(
  parameter int HW = 9,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] hc,
  input  logic [VW-1:0] vc,
  input  logic          line_end,
  input  logic          frame_end,
  input  logic [HW-1:0] h_total,
  input  logic [HW-1:0] h_bb,
  input  logic [HW-1:0] h_be,
  input  logic [HW:0]   h_db,
  input  logic [HW-1:0] h_de,
  input  logic [HW-1:0] h_ss,
  input  logic [VW-1:0] v_bb,
  input  logic [VW-1:0] v_be,
  input  logic [VW-1:0] v_db,
  input  logic [VW-1:0] v_de,
  input  logic [VW-1:0] v_ss,
  input  logic          hpol,
  input  logic          vpol,
  output logic          hsync,
  output logic          vsync,
  output logic          disp_en,
  output logic          border_en,
  output logic          eol,
  output logic          eof
);
  logic [HW:0] half_len, hdb_eff;
  logic        h_disp, v_disp, h_bord, v_bord, disp_now;

  assign half_len = ({1'b0, h_total} + (HW+1)'(1)) >> 1;
  assign hdb_eff  = {1'b0, h_db[HW-1:0]} + (h_db[HW] ? half_len : '0);
  assign h_disp   = ({1'b0, hc} >= hdb_eff) && (hc < h_de);
  assign v_disp   = (vc >= v_db) && (vc < v_de);
  assign h_bord   = (hc >= h_bb) && (hc < h_be);
  assign v_bord   = (vc >= v_bb) && (vc < v_be);
  assign disp_now = h_disp && v_disp;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync     <= ~hpol;
      vsync     <= ~vpol;
      disp_en   <= 1'b0;
      border_en <= 1'b0;
      eol       <= 1'b0;
      eof       <= 1'b0;
    end else begin
      hsync     <= (hc >= h_ss) == hpol;
      vsync     <= (vc >= v_ss) == vpol;
      disp_en   <= disp_now;
      border_en <= h_bord && v_bord && !disp_now;
      eol       <= line_end;
      eof       <= frame_end;
    end
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen import rtg_pkg::*; #(
  parameter int HW = 9,
  parameter int VW = 11,
  parameter int AW = 4,
  parameter int RST_H [6] = '{63, 2, 60, 8, 56, 58},
  parameter int RST_V [6] = '{39, 2, 36, 4, 32, 34},
  parameter int RST_CTRL = 0,
  parameter int RST_MODE = 8,
  localparam int DW = (VW > HW + 1) ? VW : HW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          pix_en,
  output logic          hsync,
  output logic          vsync,
  output logic          disp_en,
  output logic          border_en,
  output logic          eol,
  output logic          eof,
  output logic          field,
  output logic [VW-1:0] fetch_line
);
  logic [HW-1:0] h_total, h_bb, h_be, h_de, h_ss;
  logic [HW:0]   h_db;
  logic [VW-1:0] v_total, v_bb, v_be, v_db, v_de, v_ss;
  logic          hpol, vpol, dscan, ilace;
  logic [1:0]    div;
  logic          tick, line_end, frame_end;
  logic [HW-1:0] hc;
  logic [VW-1:0] vc;

  rtg_regs #(
    .HW(HW), .VW(VW), .DW(DW), .AW(AW),
    .RST_H(RST_H), .RST_V(RST_V), .RST_CTRL(RST_CTRL), .RST_MODE(RST_MODE)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(frame_end),
    .h_total(h_total), .h_bb(h_bb), .h_be(h_be), .h_db(h_db), .h_de(h_de),
    .h_ss(h_ss), .v_total(v_total), .v_bb(v_bb), .v_be(v_be), .v_db(v_db),
    .v_de(v_de), .v_ss(v_ss), .hpol(hpol), .vpol(vpol), .dscan(dscan),
    .ilace(ilace), .div(div)
  );

  rtg_tick u_tick (
    .clk(clk), .rst(rst), .pix_en(pix_en), .div(div), .tick(tick)
  );

  rtg_counters #(.HW(HW), .VW(VW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .h_total(h_total), .v_total(v_total),
    .v_db(v_db), .v_de(v_de), .ilace(ilace), .dscan(dscan),
    .hc(hc), .vc(vc), .field(field), .fetch_line(fetch_line),
    .line_end(line_end), .frame_end(frame_end)
  );

  rtg_decode #(.HW(HW), .VW(VW)) u_dec (
    .clk(clk), .rst(rst), .hc(hc), .vc(vc), .line_end(line_end),
    .frame_end(frame_end), .h_total(h_total), .h_bb(h_bb), .h_be(h_be),
    .h_db(h_db), .h_de(h_de), .h_ss(h_ss), .v_bb(v_bb), .v_be(v_be),
    .v_db(v_db), .v_de(v_de), .v_ss(v_ss), .hpol(hpol), .vpol(vpol),
    .hsync(hsync), .vsync(vsync), .disp_en(disp_en), .border_en(border_en),
    .eol(eol), .eof(eof)
  );
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int HW = 9,
  parameter int VW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic [HW-1:0] hc,
  input logic [HW-1:0] h_total,
  input logic [VW-1:0] v_total,
  input logic          ilace,
  input logic          frame_end,
  input logic          eol,
  input logic          eof,
  input logic          disp_en,
  input logic          border_en,
  input logic          field,
  input logic [VW-1:0] fetch_line
);
  p_eof_with_eol_r4: assert property (@(posedge clk) disable iff (rst)
    eof |-> eol);

  p_disp_border_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(disp_en && border_en));

  p_hc_in_period_r3: assert property (@(posedge clk) disable iff (rst)
    hc <= h_total);

  p_hc_moves_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(hc));

  p_field_toggle_r8: assert property (@(posedge clk) disable iff (rst)
    (eof && $past(ilace)) |-> (field != $past(field)));

  p_field_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (eof && !$past(ilace)) |-> !field);

  p_fetch_step_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fetch_line == $past(fetch_line) ||
              fetch_line == $past(fetch_line) + VW'(1) || fetch_line == '0));

  p_active_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> ($stable(h_total) && $stable(v_total) && $stable(ilace)));
endmodule

bind raster_timing_gen rtg_checker #(.HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .hc(hc), .h_total(h_total),
  .v_total(v_total), .ilace(ilace), .frame_end(frame_end), .eol(eol),
  .eof(eof), .disp_en(disp_en), .border_en(border_en), .field(field),
  .fetch_line(fetch_line)
);

// File: tb/raster_timing_gen_test.sv
`timescale 1ns/1ps
module raster_timing_gen_test;
  localparam int NCFG = 6;
  localparam int RH [6] = '{63, 2, 60, 8, 56, 58};
  localparam int RV [6] = '{39, 2, 36, 4, 32, 34};

  // per config: 14 register values, pix_en pattern, cycles to run
  localparam logic [15:0] CFG [NCFG][14] = '{
    '{16'd19, 16'd1, 16'd18, 16'd4,     16'd14, 16'd16, 16'd15, 16'd1, 16'd14, 16'd2, 16'd12, 16'd13, 16'd0, 16'h8},
    '{16'd19, 16'd1, 16'd19, 16'h204,   16'd19, 16'd16, 16'd15, 16'd1, 16'd14, 16'd2, 16'd12, 16'd13, 16'd3, 16'hA},
    '{16'd23, 16'd2, 16'd22, 16'd3,     16'd20, 16'd18, 16'd17, 16'd0, 16'd16, 16'd0, 16'd14, 16'd15, 16'd1, 16'h9},
    '{16'd9,  16'd1, 16'd9,  16'd2,     16'd8,  16'd7,  16'd9,  16'd1, 16'd8,  16'd2, 16'd8,  16'd7,  16'd2, 16'h3},
    '{16'd11, 16'd0, 16'd11, 16'd1,     16'd10, 16'd9,  16'd11, 16'd0, 16'd10, 16'd1, 16'd9,  16'd10, 16'd0, 16'h4},
    '{16'd7,  16'd1, 16'd6,  16'd2,     16'd5,  16'd6,  16'd7,  16'd0, 16'd7,  16'd1, 16'd6,  16'd6,  16'd3, 16'hC}
  };
  localparam int PIXPAT [NCFG] = '{0, 0, 1, 0, 1, 0};
  localparam int RUNC   [NCFG] = '{1500, 800, 1200, 700, 400, 300};

  logic        clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = 0;
  logic [10:0] wr_data = 0;
  logic        pix_en = 1;
  logic        hsync, vsync, disp_en, border_en, eol, eof, field;
  logic [10:0] fetch_line;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  logic [15:0] ms [14], ma [14];
  int mhc, mvc, mfield, mfl, mds, mcnt;

  always #2.5 clk = ~clk;

  raster_timing_gen #(.RST_H(RH), .RST_V(RV), .RST_CTRL(0), .RST_MODE(8)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pix_en(pix_en), .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
    .border_en(border_en), .eol(eol), .eof(eof), .field(field),
    .fetch_line(fetch_line)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 14; i++) begin
      ms[i] = (i < 6) ? 16'(RH[i]) : (i < 12) ? 16'(RV[i-6]) : (i == 12) ? 16'd0 : 16'd8;
      ma[i] = ms[i];
    end
    mhc = 0; mvc = 0; mfield = 0; mfl = 0; mds = 0; mcnt = 0;
  endtask

  // one clock: drive inputs, predict, advance model, compare after the edge
  task automatic step(input bit we, input int a, input logic [15:0] d, input bit pe);
    int lim, hdb, htot, vtot;
    bit tk, le, fe, e_hs, e_vs, e_dp, e_bd, hdp, vdp, il, dsn;
    wr_en = we; wr_addr = 4'(a); wr_data = d[10:0]; pix_en = pe;
    lim  = (ma[13][3:2] == 2'b00) ? 3 : (ma[13][3:2] == 2'b01) ? 1 : 0;
    htot = int'(ma[0][8:0]);
    vtot = int'(ma[6][10:0]);
    tk   = pe && (mcnt >= lim);
    le   = tk && (mhc >= htot);
    fe   = le && (mvc + 2 > vtot);
    hdb  = int'(ma[3][8:0]) + (ma[3][9] ? (htot + 1) / 2 : 0);
    e_hs = (mhc >= int'(ma[5][8:0])) == ma[12][0];
    e_vs = (mvc >= int'(ma[11][10:0])) == ma[12][1];
    hdp  = (mhc >= hdb) && (mhc < int'(ma[4][8:0]));
    vdp  = (mvc >= int'(ma[9][10:0])) && (mvc < int'(ma[10][10:0]));
    e_dp = hdp && vdp;
    e_bd = !e_dp && (mhc >= int'(ma[1][8:0])) && (mhc < int'(ma[2][8:0])) &&
           (mvc >= int'(ma[7][10:0])) && (mvc < int'(ma[8][10:0]));
    il   = ma[13][1];
    dsn  = ma[13][0];
    if (tk) mcnt = 0; else if (pe) mcnt++;
    if (tk) begin
      if (le) begin
        mhc = 0;
        if (fe) begin
          mvc = (il && mfield == 0) ? 1 : 0;
          mfield = il ? 1 - mfield : 0;
          mfl = 0; mds = 0;
        end else begin
          mvc += 2;
          if (vdp) begin
            if (dsn) begin if (mds == 1) mfl++; mds = 1 - mds; end
            else mfl++;
          end
        end
      end else mhc++;
    end
    if (fe) for (int i = 0; i < 14; i++) ma[i] = ms[i];
    if (we && a < 14) begin
      case (a)
        0, 1, 2, 4, 5: ms[a] = {7'd0, d[8:0]};
        3:             ms[a] = {6'd0, d[9:0]};
        12:            ms[a] = {14'd0, d[1:0]};
        13:            ms[a] = {12'd0, d[3:0]};
        default:       ms[a] = {5'd0, d[10:0]};
      endcase
    end
    @(posedge clk);
    cyc++;
    #1;
    wr_en = 0;
    check("R5 (shadow load R10)", "hsync", int'(hsync), int'(e_hs));
    check("R5", "vsync", int'(vsync), int'(e_vs));
    check("R6", "disp_en", int'(disp_en), int'(e_dp));
    check("R7", "border_en", int'(border_en), int'(e_bd));
    check("R3", "eol", int'(eol), int'(le));
    check("R4", "eof", int'(eof), int'(fe));
    check("R8", "field", int'(field), mfield);
    check("R9", "fetch_line", int'(fetch_line), mfl);
  endtask

  function automatic bit pix_of(input int pat, input int c);
    return (pat == 0) ? 1'b1 : ((c % 3) != 0);
  endfunction

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", "hsync", int'(hsync), 1);
    check("R1", "vsync", int'(vsync), 1);
    check("R1", "disp_en", int'(disp_en), 0);
    check("R1", "border_en", int'(border_en), 0);
    check("R1", "eol/eof", int'({eol, eof}), 0);
    check("R1", "field", int'(field), 0);
    check("R1", "fetch_line", int'(fetch_line), 0);
    rst = 0;

    // table walk: program each configuration mid-frame, then run
    for (int k = 0; k < NCFG; k++) begin
      for (int r = 0; r < 14; r++) step(1, r, CFG[k][r], pix_of(PIXPAT[k], cyc));
      step(1, 14, 16'h7FF, 1);   // R10: unmapped address ignored
      step(1, 15, 16'h000, 1);
      for (int n = 0; n < RUNC[k]; n++) step(0, 0, 16'd0, pix_of(PIXPAT[k], cyc));
    end

    // R2: divide-by-4 measured as eol spacing, h_total 9 -> 40 clocks
    begin
      int first, gap;
      step(1, 0, 16'd9, 1);
      step(1, 13, 16'h0, 1);
      for (int n = 0; n < 300; n++) step(0, 0, 16'd0, 1);
      first = -1; gap = 0;
      for (int n = 0; n < 200 && gap == 0; n++) begin
        step(0, 0, 16'd0, 1);
        if (eol) begin
          if (first < 0) first = cyc;
          else gap = cyc - first;
        end
      end
      check("R2", "eol spacing div4", gap, 40);
    end

    // R1: reset again mid-frame returns to the reset state
    rst = 1;
    @(posedge clk); #1;
    check("R1", "disp after reset", int'(disp_en), 0);
    check("R1", "fetch after reset", int'(fetch_line), 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule